// File: doc/BRIEF.md
# Block and Frame Synchronisation Guard

This block keeps track of block alignment and frame alignment in a received stream made of fixed-length blocks, 272 bits each, grouped 272 blocks to a frame. An upstream correlator supplies the raw results. It gives a one-cycle strobe when a sync word has just ended, the number of bit errors in that word, and a flag that marks the word as a frame-start word. A bit enable advances the block's timing by one bit. The block turns these noisy hits into two clean lock levels, a bit position, a block number within the frame, and one-cycle start pulses.

Each level uses a pair of protection counters. While a level is unlocked, it needs a run of good, correctly spaced hits before it claims lock. While it is locked, it needs a run of misses at the expected positions before it lets go. A single bad or missing word therefore neither drops a held lock nor creates a false one. Run lengths are programmed as the count minus one in 4-bit fields. The error tolerance is separate for acquiring and for keeping block lock. Frame lock rides on block lock, and it is cleared as soon as block lock is lost.

Top module: `sync_prot`

## Requirements
- R1: During and after reset all outputs are 0: both lock levels, both start pulses, the bit position and the block number.
- R2: While block lock is not held, block lock rises with the detection that completes a run of blk_acq_m1_i+1 consecutive accepted detections. Consecutive detections in the run are BLK_BITS enabled bits apart. While acquiring, a detection is accepted when sync_err_i <= tol_acq_i.
- R3: While acquiring, a missing or rejected detection at the expected position empties the run. An accepted detection at any other position restarts the run at 1 and re-aligns the bit position to 0.
- R4: While block lock is held, only the expected position counts. There, a missing detection, or one with sync_err_i > tol_keep_i, adds to a miss run. An accepted one empties the run. Block lock falls when the miss run reaches blk_keep_m1_i+1. Detections at other positions are ignored.
- R5: A programmed protection field of 0 means a run length of 1, so a single event changes the state.
- R6: blk_start_o is a one-cycle pulse in the cycle after each expected-position bit at which block lock is held afterwards, including the bit that gains lock. The pulse keeps coming every BLK_BITS bits across misses that do not drop lock.
- R7: Frame lock can only be gained while block lock is held. It rises after frm_acq_m1_i+1 consecutive frame-marked, accepted block syncs that lie FRM_BLKS blocks apart. A frame-marked sync at any other block number re-aligns the block number to 0 and restarts the run at 1.
- R8: While frame lock is held, each block number FRM_BLKS-1 boundary without a frame-marked accepted sync adds a miss. Frame lock falls after frm_keep_m1_i+1 consecutive misses.
- R9: When block lock falls, frame lock falls at the same clock edge, and the block number returns to 0.
- R10: blk_num_o counts the block starts modulo FRM_BLKS. frm_start_o pulses together with blk_start_o at block 0 of each frame while frame lock is held.
- R11: While bit_en_i is 0 nothing advances and sync_det_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One received bit per enabled cycle |
| sync_det_i | input | 1 | Sync word just ended at this bit |
| sync_err_i | input | ERR_W | Bit errors in the detected sync word |
| frame_mark_i | input | 1 | Detected word is a frame-start word |
| tol_acq_i | input | 4 | Error tolerance while acquiring block lock |
| tol_keep_i | input | 4 | Error tolerance while keeping block lock |
| blk_acq_m1_i | input | 4 | Block acquire run length minus one |
| blk_keep_m1_i | input | 4 | Block loss run length minus one |
| frm_acq_m1_i | input | 4 | Frame acquire run length minus one |
| frm_keep_m1_i | input | 4 | Frame loss run length minus one |
| blk_lock_o | output | 1 | Block lock held |
| frm_lock_o | output | 1 | Frame lock held |
| blk_start_o | output | 1 | One-cycle block start pulse |
| frm_start_o | output | 1 | One-cycle frame start pulse |
| bit_pos_o | output | clog2(BLK_BITS) | Bit position within the block |
| blk_num_o | output | clog2(FRM_BLKS) | Block number within the frame |

## Verification
The two functions that can fall in the same cycle are the block-level decision and the frame-level decision, because both are taken on the bit that ends a sync word. In the vector table, the frame-marked word that completes the frame run arrives on a block boundary. This must give a block-start pulse and a frame-start pulse in the same cycle, with the block number at 0. A block miss run that ends on a bit where frame lock is held must drop both lock levels at one edge. The bench provokes both cases with the spacing of the blocks and compares all outputs after each block against values worked out by hand.

// File: rtl/sync_prot_pkg.sv
package sync_prot_pkg;
  localparam int PROT_W = 4;
  localparam int RUN_W  = PROT_W + 1;

  typedef logic [PROT_W-1:0] prot_field_t;
  typedef logic [RUN_W-1:0]  run_t;

  // A field holds the run length minus one, so zero means one event.
  function automatic run_t prot_count(input prot_field_t f);
    return run_t'(f) + run_t'(1);
  endfunction
endpackage

// File: rtl/sync_prot_tol.sv
module sync_prot_tol #(
  parameter int ERR_W = 5,
  parameter int TOL_W = 4
) (
  input  logic [ERR_W-1:0] err_i,
  input  logic [TOL_W-1:0] tol_acq_i,
  input  logic [TOL_W-1:0] tol_keep_i,
  output logic             ok_acq_o,
  output logic             ok_keep_o
);
  localparam int CMP_W = (ERR_W > TOL_W) ? ERR_W : TOL_W;

  logic [CMP_W-1:0] err_x, acq_x, keep_x;

  always_comb begin
    err_x     = CMP_W'(err_i);
    acq_x     = CMP_W'(tol_acq_i);
    keep_x    = CMP_W'(tol_keep_i);
    ok_acq_o  = (err_x <= acq_x);
    ok_keep_o = (err_x <= keep_x);
  end
endmodule

// File: rtl/sync_prot_guard.sv
module sync_prot_guard
  import sync_prot_pkg::*;
#(
  parameter int PERIOD = 272,
  localparam int POS_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             hit_acq_i,
  input  logic             hit_keep_i,
  input  prot_field_t      acq_m1_i,
  input  prot_field_t      keep_m1_i,
  output logic             lock_o,
  output logic             lock_next_o,
  output logic             wrap_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PERIOD - 1);

  logic [POS_W-1:0] pos_q, pos_d, pos_adv;
  run_t             run_q, run_d, run_inc;
  logic             lock_q, lock_d;
  logic             at_slot;

  always_comb begin
    at_slot = step_i && (pos_q == LAST);
    pos_adv = at_slot ? '0 : pos_q + 1'b1;
    run_inc = run_q + 1'b1;
    pos_d   = pos_q;
    run_d   = run_q;
    lock_d  = lock_q;
    if (clr_i) begin
      pos_d  = '0;
      run_d  = '0;
      lock_d = 1'b0;
    end else if (step_i) begin
      pos_d = pos_adv;
      if (!lock_q) begin
        if (hit_acq_i) begin
          if (at_slot && (run_q != '0)) begin
            run_d = run_inc;
          end else begin
            run_d = run_t'(1);
            pos_d = '0;
          end
          if (run_d == prot_count(acq_m1_i)) begin
            lock_d = 1'b1;
            run_d  = '0;
          end
        end else if (at_slot) begin
          run_d = '0;
        end
      end else if (at_slot) begin
        if (hit_keep_i) begin
          run_d = '0;
        end else begin
          run_d = run_inc;
          if (run_d == prot_count(keep_m1_i)) begin
            lock_d = 1'b0;
            run_d  = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (step_i || clr_i) begin
      pos_q  <= pos_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o      = lock_q;
  assign lock_next_o = lock_d;
  assign wrap_o      = step_i && !clr_i && (pos_d == '0);
  assign pos_o       = pos_q;
endmodule

// File: rtl/sync_prot.sv
module sync_prot
  import sync_prot_pkg::*;
#(
  parameter int BLK_BITS = 272,
  parameter int FRM_BLKS = 272,
  parameter int ERR_W    = 5,
  localparam int BIT_W   = $clog2(BLK_BITS),
  localparam int NUM_W   = $clog2(FRM_BLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en_i,
  input  logic             sync_det_i,
  input  logic [ERR_W-1:0] sync_err_i,
  input  logic             frame_mark_i,
  input  logic [3:0]       tol_acq_i,
  input  logic [3:0]       tol_keep_i,
  input  logic [3:0]       blk_acq_m1_i,
  input  logic [3:0]       blk_keep_m1_i,
  input  logic [3:0]       frm_acq_m1_i,
  input  logic [3:0]       frm_keep_m1_i,
  output logic             blk_lock_o,
  output logic             frm_lock_o,
  output logic             blk_start_o,
  output logic             frm_start_o,
  output logic [BIT_W-1:0] bit_pos_o,
  output logic [NUM_W-1:0] blk_num_o
);
  logic rst_meta, rst_sync;
  logic ok_acq, ok_keep, det_step;
  logic blk_hit_acq, blk_hit_keep, blk_accept;
  logic blk_lock, blk_lock_nx, blk_wrap, blk_mark;
  logic frm_lock, frm_lock_nx, frm_wrap, frm_mark, frm_hit, frm_clr;
  logic blk_start_q, frm_start_q;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sync_prot_tol #(.ERR_W(ERR_W), .TOL_W(PROT_W)) u_tol (
    .err_i      (sync_err_i),
    .tol_acq_i  (tol_acq_i),
    .tol_keep_i (tol_keep_i),
    .ok_acq_o   (ok_acq),
    .ok_keep_o  (ok_keep)
  );

  always_comb begin
    det_step     = bit_en_i && sync_det_i;
    blk_hit_acq  = det_step && ok_acq;
    blk_hit_keep = det_step && ok_keep;
    blk_accept   = blk_lock ? blk_hit_keep : blk_hit_acq;
  end

  sync_prot_guard #(.PERIOD(BLK_BITS)) u_blk (
    .clk         (clk),
    .rst_n       (rst_sync),
    .clr_i       (1'b0),
    .step_i      (bit_en_i),
    .hit_acq_i   (blk_hit_acq),
    .hit_keep_i  (blk_hit_keep),
    .acq_m1_i    (blk_acq_m1_i),
    .keep_m1_i   (blk_keep_m1_i),
    .lock_o      (blk_lock),
    .lock_next_o (blk_lock_nx),
    .wrap_o      (blk_wrap),
    .pos_o       (bit_pos_o)
  );

  always_comb begin
    blk_mark = blk_wrap && blk_lock_nx;
    frm_clr  = !blk_lock_nx;
    frm_hit  = blk_mark && blk_accept && frame_mark_i;
  end

  sync_prot_guard #(.PERIOD(FRM_BLKS)) u_frm (
    .clk         (clk),
    .rst_n       (rst_sync),
    .clr_i       (frm_clr),
    .step_i      (blk_mark),
    .hit_acq_i   (frm_hit),
    .hit_keep_i  (frm_hit),
    .acq_m1_i    (frm_acq_m1_i),
    .keep_m1_i   (frm_keep_m1_i),
    .lock_o      (frm_lock),
    .lock_next_o (frm_lock_nx),
    .wrap_o      (frm_wrap),
    .pos_o       (blk_num_o)
  );

  assign frm_mark = frm_wrap && frm_lock_nx;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      blk_start_q <= 1'b0;
      frm_start_q <= 1'b0;
    end else begin
      blk_start_q <= blk_mark;
      frm_start_q <= frm_mark;
    end
  end

  assign blk_lock_o  = blk_lock;
  assign frm_lock_o  = frm_lock;
  assign blk_start_o = blk_start_q;
  assign frm_start_o = frm_start_q;
endmodule

// File: rtl/sync_prot_chk.sv
module sync_prot_chk #(
  parameter int NUM_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             sync_det,
  input logic             blk_lock,
  input logic             frm_lock,
  input logic             blk_start,
  input logic             frm_start,
  input logic [NUM_W-1:0] blk_num
);
  assert_frame_needs_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_lock |-> blk_lock);

  assert_frame_drops_with_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_lock) |-> !frm_lock);

  assert_start_only_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> blk_lock);

  assert_frame_start_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> (blk_start && frm_lock && (blk_num == '0)));

  assert_lock_on_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_lock) |-> $past(bit_en && sync_det));

  assert_loss_on_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_lock) |-> $past(bit_en));

  assert_frozen_without_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bit_en) |-> ($stable(blk_lock) && $stable(frm_lock) && $stable(blk_num)
                        && !blk_start && !frm_start));
endmodule

bind sync_prot sync_prot_chk #(.NUM_W(NUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en_i),
  .sync_det  (sync_det_i),
  .blk_lock  (blk_lock_o),
  .frm_lock  (frm_lock_o),
  .blk_start (blk_start_o),
  .frm_start (frm_start_o),
  .blk_num   (blk_num_o)
);

// File: tb/sync_prot_tb.sv
module sync_prot_tb;
  localparam int BLK = 8;
  localparam int FRM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, sync_det = 1'b0, frame_mark = 1'b0;
  logic [4:0] sync_err = '0;
  logic [3:0] tol_acq, tol_keep, blk_acq, blk_keep, frm_acq, frm_keep;
  logic       blk_lock, frm_lock, blk_start, frm_start;
  logic [2:0] bit_pos;
  logic [1:0] blk_num;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_prot #(.BLK_BITS(BLK), .FRM_BLKS(FRM), .ERR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en), .sync_det_i(sync_det),
    .sync_err_i(sync_err), .frame_mark_i(frame_mark),
    .tol_acq_i(tol_acq), .tol_keep_i(tol_keep),
    .blk_acq_m1_i(blk_acq), .blk_keep_m1_i(blk_keep),
    .frm_acq_m1_i(frm_acq), .frm_keep_m1_i(frm_keep),
    .blk_lock_o(blk_lock), .frm_lock_o(frm_lock),
    .blk_start_o(blk_start), .frm_start_o(frm_start),
    .bit_pos_o(bit_pos), .blk_num_o(blk_num)
  );

  typedef struct packed {
    logic       det;
    logic [4:0] err;
    logic       fm;
    logic       bl, bs, fl, fs;
    logic [1:0] num;
  } vec_t;

  // One entry per block; the detection sits on the last bit of the block.
  localparam vec_t VEC [33] = '{
    '{1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    '{1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3},
    '{1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
    '{1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
    '{1'b1, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3},
    '{1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3},
    '{1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {blk_lock, blk_start, frm_lock, frm_start, blk_num};
  endfunction

  task automatic step(input logic en, input logic det, input logic [4:0] err, input logic fm);
    @(negedge clk);
    bit_en = en; sync_det = det; sync_err = err; frame_mark = fm;
    @(posedge clk);
    #1;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 5'd0, 1'b0);
  endtask

  task automatic send_block(input logic det, input logic [4:0] err, input logic fm);
    gap(BLK - 1);
    step(1'b1, det, err, fm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; sync_det = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset outputs", {26'd0, outs()}, 32'd0);
    check("R1 reset bit_pos", {29'd0, bit_pos}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // Table phase: acquire 3, keep 2 for blocks; 2 and 2 for frames.
    tol_acq = 4'd2; tol_keep = 4'd3;
    blk_acq = 4'd2; blk_keep = 4'd1; frm_acq = 4'd1; frm_keep = 4'd1;
    do_reset();
    for (int v = 0; v < 33; v++) begin
      send_block(VEC[v].det, VEC[v].err, VEC[v].fm);
      // Rows cover R2 R3 R4 R6 R7 R8 R9 R10.
      check($sformatf("R2_R10 vector %0d", v), {26'd0, outs()},
            {26'd0, VEC[v].bl, VEC[v].bs, VEC[v].fl, VEC[v].fs, VEC[v].num});
    end

    // R5: zero fields mean a run of one.
    blk_acq = 4'd0; blk_keep = 4'd0; frm_acq = 4'd0; frm_keep = 4'd0;
    tol_acq = 4'd2; tol_keep = 4'd2;
    do_reset();
    send_block(1'b1, 5'd0, 1'b1);
    check("R5 single hit locks block and frame", {26'd0, outs()}, {26'd0, 6'b111100});

    // R11: no step while bit_en is low, detections ignored.
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, 5'd0, 1'b1);
      check("R11 frozen without bit_en", {26'd0, outs()}, {26'd0, 6'b101000});
    end
    send_block(1'b1, 5'd0, 1'b0);
    check("R11 timing kept after pause", {26'd0, outs()}, {26'd0, 6'b111001});

    // R4: an off-position detection is ignored while locked.
    gap(3);
    step(1'b1, 1'b1, 5'd0, 1'b1);
    check("R4 off-position detection ignored", {26'd0, outs()}, {26'd0, 6'b101001});
    check("R4 bit position advances", {29'd0, bit_pos}, 32'd4);
    send_block(1'b0, 5'd0, 1'b0);
    check("R4 R9 single miss drops both locks", {26'd0, outs()}, 32'd0);

    // R2 R3 with the default fields: acquire 8, keep 2, tolerance 2.
    blk_acq = 4'd7; blk_keep = 4'd1; frm_acq = 4'd7; frm_keep = 4'd1;
    do_reset();
    for (int i = 0; i < 7; i++) send_block(1'b1, 5'd2, 1'b0);
    check("R2 seven hits do not lock", {31'd0, blk_lock}, 32'd0);
    gap(3);
    step(1'b1, 1'b1, 5'd0, 1'b0);
    check("R3 misplaced hit restarts run", {31'd0, blk_lock}, 32'd0);
    check("R3 misplaced hit realigns", {29'd0, bit_pos}, 32'd0);
    for (int i = 0; i < 6; i++) send_block(1'b1, 5'd1, 1'b0);
    check("R2 run of seven after restart", {31'd0, blk_lock}, 32'd0);
    send_block(1'b1, 5'd0, 1'b0);
    check("R2 eighth hit locks", {30'd0, blk_lock, blk_start}, 32'd3);
    send_block(1'b0, 5'd0, 1'b0);
    check("R6 pulse continues over a miss", {30'd0, blk_lock, blk_start}, 32'd3);
    step(1'b1, 1'b0, 5'd0, 1'b0);
    check("R6 pulse lasts one cycle", {31'd0, blk_start}, 32'd0);
    gap(BLK - 2);
    step(1'b1, 1'b0, 5'd0, 1'b0);
    check("R4 second miss drops lock", {30'd0, blk_lock, blk_start}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule